// File: doc/BRIEF.md
# Multi-Port GPIO Unit with Indirect Pin Configuration

This block drives and samples 29 general-purpose pins arranged as four 8-bit ports. Pin n sits in port n/8 at bit n%8, so port 3 carries only five live bits. A small byte-wide register window gives software a data-out and a data-in register for every port. Ports 0 and 1 also have an event-enable and an event-status register, which latch rising edges on the synchronised inputs.

The electrical setup of a pin is not mapped per port. Software first writes a selector byte that names one pin: the port number in bits 6:4 and the bit position in bits 2:0. It then reads or writes a single shared configuration byte that holds that pin's output enable, drive type and pull-up. The block computes one effective drive enable per pin from that setting and the pin's output value. Pad cells and interrupt routing sit outside this block.

Top module: `gpio_ports`

## Requirements
- R1: After reset all data-out, event and configuration state is 0, the selector is 0, no pin is driven, and every register reads 0 while the pads are low.
- R2: Data-out registers sit at 0x00 (port 0), 0x04 (port 1), 0x08 (port 2) and 0x0A (port 3). They read back the last full byte written. Bit k of port p drives pad_out[8p+k].
- R3: Data-in registers sit at 0x01, 0x05, 0x09 and 0x0B. They return the pad level through two flops, so a change is visible on the second clock edge after it. Port 3 bits 7:5 read 0.
- R4: Event-enable sits at 0x02 (port 0) and 0x06 (port 1). Event-status sits at 0x03 and 0x07. A status bit is set when its synchronised input rises while its enable bit is 1. No status bit is set without such a rise.
- R5: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. A steady high level or a falling edge does not set it again.
- R6: The selector at 0xF0 stores bits 6:4 (port) and 2:0 (bit). It reads back with bits 7 and 3 as 0.
- R7: The configuration byte at 0xF1 acts on the selected pin only. Bit 0 is output enable, bit 1 selects push-pull (0 means open-drain), and bit 2 enables the pull-up. Bits 7:3 read 0. These bits appear on pad_pushpull and pad_pullup.
- R8: A pin is driven only when its output enable is 1 and it is either in push-pull mode or outputs 0. An open-drain pin holding 1 is not driven.
- R9: When the selector names pin 29 or above, 0xF1 reads 0x00 and writes to it change no pin's configuration.
- R10: Any other address, including the reserved index 0xF2, reads 0x00. A write to it changes no register or pad output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| pad_in | input | 29 | Pad input levels |
| pad_out | output | 29 | Output value per pin |
| pad_drive_en | output | 29 | Effective drive enable per pin |
| pad_pushpull | output | 29 | 1 for push-pull, 0 for open-drain |
| pad_pullup | output | 29 | Pull-up enable per pin |

## Verification
Data-out is written with a different byte per port, and port 3 gets all ones, so a swapped port offset or a lost bit of a 5-bit port shows up on pad_out. The input pattern has a distinct byte in each port and is read on the first and second edge after it changes, which separates a one-flop from a two-flop path. Event tests raise every input of ports 0 and 1 under partial enable masks, then hold the inputs high and drop them, which tells edge latching apart from level latching. Configuration is written through valid and invalid selectors on pins in different ports, together with both output values in open-drain mode, to exercise the drive rule.

// File: rtl/gpio_ports.sv
module gpio_ports #(
  parameter int NPINS = 29,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_drive_en,
  output logic [NPINS-1:0] pad_pushpull,
  output logic [NPINS-1:0] pad_pullup
);
  localparam int NPORTS = (NPINS + 7) / 8;
  localparam int FULL   = NPORTS * 8;
  localparam int NEV    = 16;
  localparam logic [AW-1:0] A_SEL = AW'(8'hF0);
  localparam logic [AW-1:0] A_CFG = AW'(8'hF1);

  function automatic logic [AW-1:0] dout_off(input int p);
    return (p < 2) ? AW'(4 * p) : AW'(8 + 2 * (p - 2));
  endfunction

  logic [FULL-1:0]  dout_q, s1_q, s2_q, prev_q, in_ext;
  logic [NEV-1:0]   ev_en_q, ev_st_q, ev_set;
  logic [7:0]       sel_q;
  logic [NPINS-1:0] oe_q, pp_q, pu_q;
  logic [5:0]       pin_idx;
  logic             sel_ok, cfg_wr;
  logic [2:0]       cfg_rd;

  always_comb begin
    in_ext = '0;
    in_ext[NPINS-1:0] = pad_in;
  end

  assign pin_idx = {sel_q[6:4], sel_q[2:0]};
  assign sel_ok  = (int'(pin_idx) < NPINS);
  assign cfg_wr  = bus_wr && bus_addr == A_CFG && sel_ok;
  assign ev_set  = s2_q[NEV-1:0] & ~prev_q[NEV-1:0] & ev_en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= in_ext;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
    end else if (bus_wr) begin
      for (int p = 0; p < NPORTS; p++)
        if (bus_addr == dout_off(p)) dout_q[p*8 +: 8] <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_en_q <= '0;
      ev_st_q <= '0;
    end else begin
      logic [NEV-1:0] clr;
      clr = '0;
      for (int p = 0; p < 2; p++) begin
        if (bus_wr && bus_addr == AW'(4 * p + 2)) ev_en_q[p*8 +: 8] <= bus_wdata;
        if (bus_wr && bus_addr == AW'(4 * p + 3)) clr[p*8 +: 8] = bus_wdata;
      end
      ev_st_q <= (ev_st_q & ~clr) | ev_set;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      oe_q  <= '0;
      pp_q  <= '0;
      pu_q  <= '0;
    end else begin
      if (bus_wr && bus_addr == A_SEL) sel_q <= bus_wdata & 8'h77;
      for (int i = 0; i < NPINS; i++)
        if (cfg_wr && pin_idx == 6'(i)) begin
          oe_q[i] <= bus_wdata[0];
          pp_q[i] <= bus_wdata[1];
          pu_q[i] <= bus_wdata[2];
        end
    end
  end

  always_comb begin
    cfg_rd = '0;
    for (int i = 0; i < NPINS; i++)
      if (pin_idx == 6'(i)) cfg_rd = {pu_q[i], pp_q[i], oe_q[i]};
  end

  always_comb begin
    bus_rdata = '0;
    for (int p = 0; p < NPORTS; p++) begin
      if (bus_addr == dout_off(p))          bus_rdata = dout_q[p*8 +: 8];
      if (bus_addr == dout_off(p) + AW'(1)) bus_rdata = s2_q[p*8 +: 8];
    end
    for (int p = 0; p < 2; p++) begin
      if (bus_addr == AW'(4 * p + 2)) bus_rdata = ev_en_q[p*8 +: 8];
      if (bus_addr == AW'(4 * p + 3)) bus_rdata = ev_st_q[p*8 +: 8];
    end
    if (bus_addr == A_SEL) bus_rdata = sel_q;
    if (bus_addr == A_CFG && sel_ok) bus_rdata = {5'b0, cfg_rd};
  end

  assign pad_out      = dout_q[NPINS-1:0];
  assign pad_drive_en = oe_q & (pp_q | ~pad_out);
  assign pad_pushpull = pp_q;
  assign pad_pullup   = pu_q;

  p_evt_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ev_st_q & $past(ev_set)) == $past(ev_set)));

  p_evt_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ev_st_q & ~$past(ev_st_q) & ~$past(ev_set)) == '0));

  p_od_high_undriven_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_drive_en & ~pad_pushpull & pad_out) == '0));

  p_bad_sel_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CFG && !sel_ok) |=> $stable({oe_q, pp_q, pu_q}));

  p_sync_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(s2_q[0]) |-> $past(s1_q[0]));
endmodule

// File: tb/gpio_ports_tb.sv
module gpio_ports_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [28:0] pad_in = '0;
  logic [28:0] pad_out, pad_drive_en, pad_pushpull, pad_pullup;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  gpio_ports u_dut (.clk, .rst_n, .bus_addr, .bus_wr, .bus_wdata, .bus_rdata,
                    .pad_in, .pad_out, .pad_drive_en, .pad_pushpull, .pad_pullup);

  always #4 clk = ~clk;

  always begin
    @(negedge clk);
    #1;
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = 32'(bus_rdata);
        1: act = 32'(pad_out);
        2: act = 32'(pad_drive_en);
        3: act = 32'(pad_pushpull);
        default: act = 32'(pad_pullup);
      endcase
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_addr = a;
    q.push_back('{0, e, tag});
  endtask

  task automatic pad(input int kind, input logic [31:0] e, input string tag);
    @(negedge clk);
    q.push_back('{kind, e, tag});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_in(input logic [28:0] v);
    @(negedge clk);
    pad_in = v;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 12; a++) rd(8'(a), 32'h0, "R1 reg after reset");
    rd(8'hF0, 32'h0, "R1 selector after reset");
    rd(8'hF1, 32'h0, "R1 cfg after reset");
    pad(1, 32'h0, "R1 pad_out after reset");
    pad(2, 32'h0, "R1 drive_en after reset");
    pad(3, 32'h0, "R1 pushpull after reset");

    // R2 data-out
    wr(8'h00, 8'hA5); wr(8'h04, 8'h3C); wr(8'h08, 8'hF0); wr(8'h0A, 8'hFF);
    rd(8'h00, 32'hA5, "R2 port0 readback");
    rd(8'h04, 32'h3C, "R2 port1 readback");
    rd(8'h08, 32'hF0, "R2 port2 readback");
    rd(8'h0A, 32'hFF, "R2 port3 readback");
    pad(1, 32'h1FF03CA5, "R2 pad_out mapping");
    pad(2, 32'h0, "R8 nothing driven without enable");

    // R3 synchroniser latency and port3 width
    set_in(29'h1ABCDEF1);
    rd(8'h01, 32'h00, "R3 first edge still old");
    rd(8'h01, 32'hF1, "R3 second edge new");
    rd(8'h05, 32'hDE, "R3 port1 in");
    rd(8'h09, 32'hBC, "R3 port2 in");
    rd(8'h0B, 32'h1A, "R3 port3 in upper bits zero");
    rd(8'h03, 32'h00, "R4 no event while disabled");
    set_in(29'h0);
    idle(4);

    // R4 events
    wr(8'h02, 8'h0F); wr(8'h06, 8'h80);
    set_in(29'h1FFFFFFF);
    idle(3);
    rd(8'h03, 32'h0F, "R4 port0 status masked");
    rd(8'h07, 32'h80, "R4 port1 status masked");
    rd(8'h02, 32'h0F, "R4 port0 enable readback");

    // R5 clear
    wr(8'h03, 8'h05);
    rd(8'h03, 32'h0A, "R5 write one clears");
    wr(8'h07, 8'h00);
    rd(8'h07, 32'h80, "R5 write zero keeps");
    wr(8'h03, 8'hFF);
    idle(3);
    rd(8'h03, 32'h00, "R5 high level no re-set");
    set_in(29'h0);
    idle(4);
    rd(8'h03, 32'h00, "R5 falling edge no set");

    // R6 selector
    wr(8'hF0, 8'hFF);
    rd(8'hF0, 32'h77, "R6 selector masks bits 7 and 3");
    wr(8'hF0, 8'h13);
    rd(8'hF0, 32'h13, "R6 selector readback");

    // R7 config
    wr(8'hF1, 8'hFF);
    rd(8'hF1, 32'h07, "R7 cfg pin11 upper bits zero");
    wr(8'hF0, 8'h00); wr(8'hF1, 8'h01);
    rd(8'hF1, 32'h01, "R7 cfg pin0");
    wr(8'hF0, 8'h34); wr(8'hF1, 8'h03);
    wr(8'hF0, 8'h13);
    rd(8'hF1, 32'h07, "R7 pin11 kept after other writes");
    pad(3, 32'h10000800, "R7 pushpull vector");
    pad(4, 32'h00000800, "R7 pullup vector");

    // R8 drive rule
    pad(2, 32'h10000800, "R8 open-drain high not driven");
    wr(8'h00, 8'hA4);
    pad(2, 32'h10000801, "R8 open-drain low driven");
    pad(1, 32'h1FF03CA4, "R2 pad_out after rewrite");

    // R9 invalid pin
    wr(8'hF0, 8'h35); wr(8'hF1, 8'h07);
    rd(8'hF1, 32'h00, "R9 pin29 cfg reads zero");
    rd(8'hF0, 32'h35, "R6 invalid selector readback");
    wr(8'hF0, 8'h77); wr(8'hF1, 8'h07);
    rd(8'hF1, 32'h00, "R9 pin63 cfg reads zero");
    pad(3, 32'h10000800, "R9 pushpull unchanged");
    pad(4, 32'h00000800, "R9 pullup unchanged");
    pad(2, 32'h10000801, "R9 drive unchanged");

    // R10 unmapped
    wr(8'hF2, 8'hFF); wr(8'h0C, 8'h55); wr(8'h50, 8'h55);
    rd(8'hF2, 32'h00, "R10 reserved reads zero");
    rd(8'h0C, 32'h00, "R10 unmapped reads zero");
    rd(8'h00, 32'hA4, "R10 port0 unchanged");
    rd(8'h0A, 32'hFF, "R10 port3 unchanged");
    pad(1, 32'h1FF03CA4, "R10 pad_out unchanged");

    idle(3);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule